// File: doc/BRIEF.md
# Descriptor-Chain Receive DMA Channel

This block is one receive DMA channel. It follows a linked list of buffer descriptors kept in a descriptor RAM inside the block. Software fills descriptors through a word-wide RAM port and marks each one as owned by the hardware. It then arms the channel by writing the address of the first descriptor to the head register. For each descriptor the channel takes one packet from a valid/ready word stream and stores it at consecutive addresses of an external memory port. It then hands the descriptor back to software by rewriting its mode word, and moves on to the next descriptor in the chain.

Hand-back uses the owner bit and the end-of-queue bit. Software may link a new descriptor onto the tail of a chain that is still running. If the engine read the old tail's next pointer as zero before the link was made, the old tail comes back with end-of-queue set and the head register reads zero. Software then restarts the channel by writing the new descriptor's address to the head register. Software also keeps a count of free buffers. Each finished descriptor takes one from that count. When the count is zero, the channel stalls and raises a starvation flag.

The engine state machine has seven states:
- `S_IDLE` moves to `S_NEXT` when the channel is enabled, the head is nonzero and the free count is nonzero.
- `S_NEXT`, `S_BUF`, `S_LEN` and `S_MODE` each fetch one descriptor word, in that order.
- `S_MODE` moves to `S_XFER` if the owner bit is set. If it is clear, `S_MODE` returns to `S_IDLE` and zeroes the head register.
- `S_XFER` accepts stream words and moves to `S_WB` on the word flagged last.
- `S_WB` writes the mode word back, loads the head register with the next pointer and returns to `S_IDLE`.

Top module: `bd_dma_chan`

## Requirements
- R1: After reset every register reads zero: enable (offset 0, bit 0), soft reset (offset 1, bit 0), head (offset 2), completion (offset 3) and free count (offset 4). `rx_ready` and `starved` are low.
- R2: A descriptor is four RAM words starting at its address: next pointer (+0), buffer address (+1), buffer length in data words (+2, low 11 bits) and mode word (+3). In the mode word, bit 31 marks start of packet, bit 30 end of packet, bit 29 hardware ownership and bit 28 end of queue. Bits 10:0 hold a length. A nonzero head, with the channel enabled and a nonzero free count, starts processing.
- R3: Stream words are written to the memory at the buffer address plus 0, 1, 2 and so on. Words past the buffer length are dropped.
- R4: At the end of a packet the mode word is rewritten in one write. The new value has bits 31 and 30 set, bit 29 clear, bits 10:0 equal to the number of words stored, and bit 28 set exactly when the next pointer was zero.
- R5: After write-back the head register takes the next pointer. The chain continues without software help, and the head reads zero once the chain ends.
- R6: A fetched descriptor whose owner bit is clear stops the channel. The head goes to zero, no data is accepted, nothing is written and the free count is unchanged.
- R7: A head write is taken only while the engine is in `S_IDLE`. While a descriptor is in progress, a head write is ignored.
- R8: A write to offset 4 adds the written value to the free count. Each completed descriptor subtracts one.
- R9: With the channel enabled, the head nonzero and the free count zero, `starved` is high and `rx_ready` stays low. Raising the count clears `starved` and resumes processing.
- R10: While the enable bit is 0, no descriptor is started. Setting it to 1 starts the armed chain.
- R11: Writing 1 to offset 1 makes that bit read 1 for exactly one cycle. It then clears itself, along with the enable, head, completion, free count and starvation state. The descriptor RAM keeps its contents.
- R12: The completion register reads back the last descriptor address software wrote to it.
- R13: After a chain ends with end of queue set, software can link a new descriptor and rewrite the head to restart the channel.
- R14: `mem_we` is high only in a cycle where a stream word is accepted (`rx_valid` and `rx_ready` both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| dram_we | input | 1 | Descriptor RAM write strobe from software |
| dram_addr | input | $clog2(DESC_WORDS) | Descriptor RAM word address from software |
| dram_wdata | input | 32 | Descriptor RAM write data |
| dram_rdata | output | 32 | Descriptor RAM read data (combinational) |
| rx_valid | input | 1 | Stream word valid |
| rx_ready | output | 1 | Channel accepts a stream word |
| rx_data | input | DATA_W | Stream word |
| rx_last | input | 1 | Marks the last word of a packet |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| starved | output | 1 | Armed and enabled, but no free buffers |

## Verification
The assertions check the following on every cycle:
- Memory writes happen only on accepted stream words.
- Starvation always holds `rx_ready` low.
- Every accepted last word is followed by a descriptor write-back.
- The head register stays fixed while a descriptor is being fetched or filled.
- The soft reset bit clears itself and empties the head and the free count.

Only the bench scenarios can show the following:
- The stored data and the written-back lengths, including truncation.
- The end-of-queue marking and restart after a late append.
- The stop on a software-owned descriptor.
- The effect of the enable bit.

// File: rtl/bd_dma_pkg.sv
package bd_dma_pkg;
    localparam int BIT_SOP = 31;
    localparam int BIT_EOP = 30;
    localparam int BIT_OWN = 29;
    localparam int BIT_EOQ = 28;
    localparam int LEN_W   = 11;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_SRST  = 3'd1;
    localparam logic [2:0] REG_HEAD  = 3'd2;
    localparam logic [2:0] REG_COMPL = 3'd3;
    localparam logic [2:0] REG_FREE  = 3'd4;

    typedef enum logic [2:0] {
        S_IDLE, S_NEXT, S_BUF, S_LEN, S_MODE, S_XFER, S_WB
    } eng_state_t;
endpackage

// File: rtl/bd_desc_ram.sv
module bd_desc_ram #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   sw_rdata,
    input  logic [AW-1:0] eng_raddr,
    output logic [31:0]   eng_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [31:0]   eng_wdata
);
    logic [31:0] words [DEPTH];

    // The engine write wins a same-address collision.
    always_ff @(posedge clk) begin
        if (sw_we && !(eng_we && eng_waddr == sw_addr))
            words[sw_addr] <= sw_wdata;
        if (eng_we)
            words[eng_waddr] <= eng_wdata;
    end

    assign sw_rdata  = words[sw_addr];
    assign eng_rdata = words[eng_raddr];
endmodule

// File: rtl/bd_chan_regs.sv
module bd_chan_regs import bd_dma_pkg::*; #(
    parameter int AW    = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [AW-1:0]    head,
    input  logic [CNT_W-1:0] free_cnt,
    output logic             ctrl_en,
    output logic             srst_busy,
    output logic             head_wr,
    output logic             free_wr
);
    logic [AW-1:0] compl_q;
    logic          unused_wbits;

    assign unused_wbits = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            srst_busy <= 1'b0;
            compl_q   <= '0;
        end else if (srst_busy) begin
            ctrl_en   <= 1'b0;
            srst_busy <= 1'b0;
            compl_q   <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                REG_CTRL:  ctrl_en   <= reg_wdata[0];
                REG_SRST:  srst_busy <= reg_wdata[0];
                REG_COMPL: compl_q   <= reg_wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    assign head_wr = reg_we && !srst_busy && reg_addr == REG_HEAD;
    assign free_wr = reg_we && !srst_busy && reg_addr == REG_FREE;

    always_comb begin
        unique case (reg_addr)
            REG_CTRL:  reg_rdata = {31'd0, ctrl_en};
            REG_SRST:  reg_rdata = {31'd0, srst_busy};
            REG_HEAD:  reg_rdata = 32'(head);
            REG_COMPL: reg_rdata = 32'(compl_q);
            REG_FREE:  reg_rdata = 32'(free_cnt);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bd_rx_engine.sv
module bd_rx_engine import bd_dma_pkg::*; #(
    parameter int AW     = 6,
    parameter int MEM_AW = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              head_wr,
    input  logic [AW-1:0]     head_wdata,
    input  logic              free_wr,
    input  logic [CNT_W-1:0]  free_add,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [AW-1:0]     ram_raddr,
    input  logic [31:0]       ram_rdata,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [31:0]       ram_wdata,
    output logic [AW-1:0]     head,
    output logic [CNT_W-1:0]  free_cnt,
    output logic              starved,
    output eng_state_t        state
);
    eng_state_t        state_nx;
    logic [AW-1:0]     nxt_q;
    logic [MEM_AW-1:0] bptr_q;
    logic [LEN_W-1:0]  blen_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [1:0]        word_off;
    logic              unused_rbits;

    assign unused_rbits = ^ram_rdata;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= S_IDLE;
        else if (clr) state <= S_IDLE;
        else          state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (en && head != '0 && free_cnt != '0) state_nx = S_NEXT;
            S_NEXT: state_nx = S_BUF;
            S_BUF:  state_nx = S_LEN;
            S_LEN:  state_nx = S_MODE;
            S_MODE: state_nx = ram_rdata[BIT_OWN] ? S_XFER : S_IDLE;
            S_XFER: if (rx_valid && rx_last) state_nx = S_WB;
            S_WB:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            S_BUF:   word_off = 2'd1;
            S_LEN:   word_off = 2'd2;
            S_MODE:  word_off = 2'd3;
            default: word_off = 2'd0;
        endcase
        ram_raddr = head + AW'(word_off);
        rx_ready  = (state == S_XFER);
        mem_we    = (state == S_XFER) && rx_valid && (cnt_q < blen_q);
        mem_addr  = bptr_q + MEM_AW'(cnt_q);
        mem_wdata = rx_data;
        ram_we    = (state == S_WB);
        ram_waddr = head + AW'(3);
        ram_wdata = '0;
        ram_wdata[BIT_SOP]   = 1'b1;
        ram_wdata[BIT_EOP]   = 1'b1;
        ram_wdata[BIT_EOQ]   = (nxt_q == '0);
        ram_wdata[LEN_W-1:0] = cnt_q;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0; free_cnt <= '0; starved <= 1'b0;
            nxt_q <= '0; bptr_q <= '0; blen_q <= '0; cnt_q <= '0;
        end else if (clr) begin
            head <= '0; free_cnt <= '0; starved <= 1'b0;
            nxt_q <= '0; bptr_q <= '0; blen_q <= '0; cnt_q <= '0;
        end else begin
            unique case (state)
                S_NEXT: nxt_q  <= ram_rdata[AW-1:0];
                S_BUF:  bptr_q <= ram_rdata[MEM_AW-1:0];
                S_LEN:  blen_q <= ram_rdata[LEN_W-1:0];
                S_MODE: begin
                    cnt_q <= '0;
                    if (!ram_rdata[BIT_OWN]) head <= '0;
                end
                S_XFER: if (rx_valid && cnt_q < blen_q) cnt_q <= cnt_q + 1'b1;
                S_WB:   head <= nxt_q;
                default: if (head_wr) head <= head_wdata;
            endcase
            free_cnt <= free_cnt + (free_wr ? free_add : '0)
                        - CNT_W'(state == S_WB);
            starved  <= (state == S_IDLE) && en && head != '0 && free_cnt == '0;
        end
    end
endmodule

// File: rtl/bd_dma_chan.sv
module bd_dma_chan import bd_dma_pkg::*; #(
    parameter int DESC_WORDS = 64,
    parameter int MEM_AW     = 10,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 8,
    localparam int AW        = $clog2(DESC_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dram_we,
    input  logic [AW-1:0]     dram_addr,
    input  logic [31:0]       dram_wdata,
    output logic [31:0]       dram_rdata,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              starved
);
    logic             ctrl_en, srst_busy, head_wr, free_wr;
    logic [AW-1:0]    head_q;
    logic [CNT_W-1:0] free_q;
    logic [AW-1:0]    e_raddr, e_waddr;
    logic [31:0]      e_rdata, e_wdata;
    logic             e_we;
    eng_state_t       eng_state;

    bd_chan_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .head(head_q),
        .free_cnt(free_q), .ctrl_en(ctrl_en), .srst_busy(srst_busy),
        .head_wr(head_wr), .free_wr(free_wr)
    );

    bd_desc_ram #(.DEPTH(DESC_WORDS), .AW(AW)) u_ram (
        .clk(clk), .sw_we(dram_we), .sw_addr(dram_addr), .sw_wdata(dram_wdata),
        .sw_rdata(dram_rdata), .eng_raddr(e_raddr), .eng_rdata(e_rdata),
        .eng_we(e_we), .eng_waddr(e_waddr), .eng_wdata(e_wdata)
    );

    bd_rx_engine #(.AW(AW), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(srst_busy), .en(ctrl_en),
        .head_wr(head_wr), .head_wdata(reg_wdata[AW-1:0]),
        .free_wr(free_wr), .free_add(reg_wdata[CNT_W-1:0]),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .ram_raddr(e_raddr), .ram_rdata(e_rdata),
        .ram_we(e_we), .ram_waddr(e_waddr), .ram_wdata(e_wdata),
        .head(head_q), .free_cnt(free_q), .starved(starved), .state(eng_state)
    );
endmodule

// File: rtl/bd_dma_chan_chk.sv
module bd_dma_chan_chk import bd_dma_pkg::*; #(
    parameter int AW    = 6,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             rx_last,
    input logic             mem_we,
    input logic             starved,
    input logic             srst_busy,
    input logic [AW-1:0]    head,
    input logic [CNT_W-1:0] free_cnt,
    input eng_state_t       eng_state,
    input logic             eng_dwe
);
    a_r14_write_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rx_valid && rx_ready));

    a_r9_starved_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        starved |-> !rx_ready);

    a_r4_wb_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_last && !srst_busy) |=> eng_dwe);

    a_r7_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_state == S_NEXT || eng_state == S_BUF || eng_state == S_LEN ||
          eng_state == S_XFER) && !srst_busy) |=> $stable(head));

    a_r11_srst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |=> !srst_busy);

    a_r11_srst_empties: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |=> (head == '0 && free_cnt == '0));
endmodule

bind bd_dma_chan bd_dma_chan_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_last(rx_last), .mem_we(mem_we), .starved(starved),
    .srst_busy(srst_busy), .head(head_q), .free_cnt(free_q),
    .eng_state(eng_state), .eng_dwe(e_we)
);

// File: tb/bd_dma_chan_tb_top.sv
`timescale 1ns/100ps
module bd_dma_chan_tb_top;
    localparam int DESC_WORDS = 64;
    localparam int MEM_AW     = 10;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 8;
    localparam int AW         = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0, dram_we = 1'b0, rx_valid = 1'b0, rx_last = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, dram_wdata = '0, reg_rdata, dram_rdata;
    logic [AW-1:0] dram_addr = '0;
    logic [DATA_W-1:0] rx_data = '0, mem_wdata;
    logic rx_ready, mem_we, starved;
    logic [MEM_AW-1:0] mem_addr;

    int checks = 0, errors = 0, wr_count = 0;
    bit done = 1'b0;
    logic [31:0] bmem [1024];

    always #2.5 clk = ~clk;

    bd_dma_chan #(.DESC_WORDS(DESC_WORDS), .MEM_AW(MEM_AW), .DATA_W(DATA_W),
                  .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dram_we(dram_we),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_last(rx_last), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .starved(starved)
    );

    // External memory model
    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    function automatic logic [31:0] mode_exp(int len, bit eoq);
        return 32'hC000_0000 | (eoq ? 32'h1000_0000 : 32'h0) | 32'(len);
    endfunction

    function automatic int min_i(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic ram_wr(int a, logic [31:0] d);
        @(negedge clk); dram_we = 1'b1; dram_addr = AW'(a); dram_wdata = d;
        @(negedge clk); dram_we = 1'b0;
    endtask

    task automatic ram_rd(int a, output logic [31:0] d);
        @(negedge clk); dram_addr = AW'(a); #1 d = dram_rdata;
    endtask

    task automatic put_desc(int a, int nxt, int buff, int len);
        ram_wr(a, 32'(nxt));
        ram_wr(a + 1, 32'(buff));
        ram_wr(a + 2, 32'(len));
        ram_wr(a + 3, 32'hE000_0000 | 32'(len));
    endtask

    task automatic send_pkt(int n, logic [31:0] base);
        for (int j = 0; j < n; j++) begin
            bit r;
            @(negedge clk);
            rx_valid = 1'b1; rx_data = base + 32'(j); rx_last = (j == n - 1);
            while (1) begin
                r = rx_ready;
                @(posedge clk);
                if (r) break;
                @(negedge clk);
            end
        end
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] h;
        for (int k = 0; k < 100; k++) begin
            reg_rd(3'd2, h);
            if (h == 0) break;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int wc0, bad;
        int lens [8];
        logic [31:0] bases [8];
        void'($urandom(32'd4242));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            reg_rd(3'(a), v); chk("R1 reg reset", v, 32'h0);
        end
        chk("R1 rx_ready reset", 32'(rx_ready), 32'h0);
        chk("R1 starved reset", 32'(starved), 32'h0);

        // R2 R3 R4 R5 R8 two-descriptor chain
        reg_wr(3'd0, 32'h1);
        put_desc(4, 8, 100, 8);
        put_desc(8, 0, 200, 8);
        reg_wr(3'd4, 32'd2);
        reg_rd(3'd4, v); chk("R8 free add", v, 32'd2);
        reg_wr(3'd2, 32'd4);
        send_pkt(5, 32'h1000);
        send_pkt(8, 32'h2000);
        wait_idle();
        bad = 0;
        for (int j = 0; j < 5; j++) if (bmem[100 + j] !== 32'h1000 + 32'(j)) bad++;
        for (int j = 0; j < 8; j++) if (bmem[200 + j] !== 32'h2000 + 32'(j)) bad++;
        chk("R3 R2 stored data", 32'(bad), 32'h0);
        ram_rd(7, v);  chk("R4 mode first", v, mode_exp(5, 0));
        ram_rd(11, v); chk("R4 mode tail eoq", v, mode_exp(8, 1));
        reg_rd(3'd2, v); chk("R5 head zero at end", v, 32'h0);
        reg_rd(3'd4, v); chk("R8 free decremented", v, 32'h0);

        // R3 R14 truncation
        put_desc(12, 0, 300, 3);
        reg_wr(3'd4, 32'd1);
        wc0 = wr_count;
        reg_wr(3'd2, 32'd12);
        send_pkt(6, 32'h3000);
        wait_idle();
        chk("R3 R14 truncated writes", 32'(wr_count - wc0), 32'd3);
        chk("R3 last stored word", bmem[302], 32'h3002);
        ram_rd(15, v); chk("R4 truncated length", v, mode_exp(3, 1));

        // R9 starvation
        put_desc(16, 0, 400, 4);
        reg_wr(3'd2, 32'd16);
        repeat (3) @(negedge clk);
        chk("R9 starved high", 32'(starved), 32'h1);
        chk("R9 ready low", 32'(rx_ready), 32'h0);
        reg_rd(3'd2, v); chk("R9 head kept", v, 32'd16);
        reg_wr(3'd4, 32'd1);
        repeat (3) @(negedge clk);
        chk("R9 starved cleared", 32'(starved), 32'h0);
        send_pkt(4, 32'h4000);
        wait_idle();
        ram_rd(19, v); chk("R9 resumed", v, mode_exp(4, 1));

        // R6 owner clear
        ram_wr(20, 0); ram_wr(21, 500); ram_wr(22, 4); ram_wr(23, 32'h0000_0004);
        reg_wr(3'd4, 32'd1);
        wc0 = wr_count;
        reg_wr(3'd2, 32'd20);
        repeat (10) @(negedge clk);
        reg_rd(3'd2, v); chk("R6 head zero", v, 32'h0);
        ram_rd(23, v); chk("R6 mode untouched", v, 32'h0000_0004);
        chk("R6 no writes", 32'(wr_count - wc0), 32'h0);
        reg_rd(3'd4, v); chk("R6 free unchanged", v, 32'd1);

        // R7 busy head write, R13 restart after eoq
        put_desc(24, 0, 600, 4);
        reg_wr(3'd2, 32'd24);
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (rx_ready) break;
        end
        reg_wr(3'd2, 32'd28);
        reg_rd(3'd2, v); chk("R7 busy head write ignored", v, 32'd24);
        send_pkt(2, 32'h5000);
        wait_idle();
        ram_rd(27, v); chk("R13 tail eoq", v, mode_exp(2, 1));
        put_desc(28, 0, 610, 4);
        ram_wr(24, 28);
        reg_wr(3'd4, 32'd1);
        reg_wr(3'd2, 32'd28);
        send_pkt(3, 32'h5100);
        wait_idle();
        ram_rd(31, v); chk("R13 restarted desc", v, mode_exp(3, 1));
        chk("R13 restarted data", bmem[612], 32'h5102);

        // R10 enable
        reg_wr(3'd0, 32'h0);
        put_desc(32, 0, 700, 4);
        reg_wr(3'd4, 32'd1);
        reg_wr(3'd2, 32'd32);
        repeat (6) @(negedge clk);
        chk("R10 disabled no ready", 32'(rx_ready), 32'h0);
        reg_rd(3'd2, v); chk("R10 head armed", v, 32'd32);
        reg_wr(3'd0, 32'h1);
        send_pkt(4, 32'h6000);
        wait_idle();
        ram_rd(35, v); chk("R10 ran after enable", v, mode_exp(4, 1));

        // R12 completion register
        reg_wr(3'd3, 32'd32);
        reg_rd(3'd3, v); chk("R12 completion readback", v, 32'd32);

        // R11 soft reset
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd4, 32'd5);
        reg_wr(3'd2, 32'd40);
        reg_wr(3'd1, 32'h1);
        #1 v = reg_rdata;
        reg_addr = 3'd1; #1 v = reg_rdata;
        chk("R11 srst reads one", v, 32'h1);
        @(negedge clk);
        reg_addr = 3'd1; #1 chk("R11 srst self clear", reg_rdata, 32'h0);
        for (int a = 0; a < 5; a++) begin
            reg_rd(3'(a), v); chk("R11 regs cleared", v, 32'h0);
        end
        ram_rd(35, v); chk("R11 ram kept", v, mode_exp(4, 1));

        // R3 R4 R5 random chains
        reg_wr(3'd0, 32'h1);
        for (int rnd = 0; rnd < 3; rnd++) begin
            for (int i = 0; i < 8; i++)
                put_desc(4 + 4 * i, (i == 7) ? 0 : 8 + 4 * i, 800 + 16 * i, 6);
            reg_wr(3'd4, 32'd8);
            reg_wr(3'd2, 32'd4);
            for (int i = 0; i < 8; i++) begin
                lens[i] = 1 + int'($urandom % 10);
                bases[i] = $urandom;
                send_pkt(lens[i], bases[i]);
            end
            wait_idle();
            for (int i = 0; i < 8; i++) begin
                ram_rd(7 + 4 * i, v);
                chk("R4 random mode", v, mode_exp(min_i(lens[i], 6), i == 7));
                bad = 0;
                for (int j = 0; j < min_i(lens[i], 6); j++)
                    if (bmem[800 + 16 * i + j] !== bases[i] + 32'(j)) bad++;
                chk("R3 random data", 32'(bad), 32'h0);
            end
            reg_rd(3'd2, v); chk("R5 random head end", v, 32'h0);
            reg_rd(3'd4, v); chk("R8 random free end", v, 32'h0);
        end

        finish_run();
    end
endmodule